// File: doc/BRIEF.md
# Inverted-Table Page Translator

This block turns a logical byte address into a physical RAM address using an inverted page table. There is one slot for each physical page. Each slot holds the logical page number that its physical page currently stands for, together with a 2-bit protection level. On every access the logical page number is compared against all slots in parallel. The index of the slot that matches becomes the physical page number. That number is shifted by the current page size and merged with the in-page offset.

An access that matches no valid slot is aborted. So is an access that the protection level forbids in the current processor mode. Software fills the table through a programming port, one slot per cycle. After reset every slot is invalid, so all accesses abort until the mapping is programmed. The RAM array itself lies outside the block.

Top module: `inv_page_xlat`

## Requirements
- R1: While reset is held and after reset, `rsp_valid_o`, `hit_o`, `abort_o` and `paddr_o` are 0. After reset every slot is invalid, so any access, including one to logical page 0, aborts.
- R2: An access presented with `req_i`=1 at a rising edge produces its response in the cycle after that edge, with `rsp_valid_o`=1. A cycle without a request gives `rsp_valid_o`=0, `hit_o`=0 and `abort_o`=0.
- R3: With `psz_i`=0 (4 KB), the logical page is `addr_i[24:12]`. On a permitted hit, `paddr_o` = slot index << 12 | `addr_i[11:0]`.
- R4: Codes `psz_i`=1, 2 and 3 select 8, 16 and 32 KB pages. For each step up in size, one more low bit of the logical page is dropped from the compare and moved into the offset. So `paddr_o` = index << (12+`psz_i`) | `addr_i[11+psz_i:0]`.
- R5: An access that matches no valid slot gives `hit_o`=0, `abort_o`=1 and `paddr_o`=0.
- R6: In user mode (`priv_i`=0), protection level 0 permits both reads (`wr_i`=0) and writes (`wr_i`=1).
- R7: In user mode, protection level 1 permits reads. A write to a level-1 page gives `hit_o`=1, `abort_o`=1 and `paddr_o`=0.
- R8: In user mode, protection levels 2 and 3 abort both reads and writes.
- R9: In supervisor mode (`priv_i`=1), a hit is never aborted, whatever its protection level.
- R10: When several slots match, the lowest-numbered slot is used.
- R11: A programming write takes effect for accesses presented on the next cycle. An access presented in the same cycle as the write still sees the old contents.
- R12: Reprogramming a slot replaces its earlier mapping, so the old logical page no longer hits through that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe |
| addr_i | input | 25 | Logical byte address |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| priv_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| psz_i | input | 2 | Page size: 0 = 4 KB, 1 = 8 KB, 2 = 16 KB, 3 = 32 KB |
| prog_en_i | input | 1 | Write one table slot |
| prog_idx_i | input | 7 | Slot (physical page) to write |
| prog_lpn_i | input | 13 | Logical page number, in 4 KB units |
| prog_prot_i | input | 2 | Protection level 0 to 3 |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| hit_o | output | 1 | A valid slot matched |
| abort_o | output | 1 | Access refused (miss or protection) |
| paddr_o | output | 22 | Physical address; 0 when aborted |

## Verification
Every translation result is due exactly one cycle after the edge that samples its request. A programming write is visible only to requests sampled at later edges. The driver task places each request before a rising edge and pushes the expected result into a queue at that moment. The monitor samples on the falling edge of every cycle and pops one entry whenever `rsp_valid_o` is 1. A response that arrives with an empty queue, or an entry still left in the queue at the end, counts as a miscompare. This ties each result to the cycle in which it must appear. The same-cycle programming case is driven as a single cycle, so the old contents must be seen.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_8K  = 2'd1,
    PG_16K = 2'd2,
    PG_32K = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    PROT_OPEN   = 2'd0,
    PROT_RDONLY = 2'd1,
    PROT_SYS_A  = 2'd2,
    PROT_SYS_B  = 2'd3
  } prot_e;
endpackage

// File: rtl/xlat_entry_table.sv
module xlat_entry_table #(
  parameter int unsigned N_ENT = 128,
  parameter int unsigned IDX_W = 7,
  parameter int unsigned LPN_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [LPN_W-1:0] wr_lpn_i,
  input  logic [1:0]       wr_prot_i,
  output logic             vld_o  [N_ENT],
  output logic [LPN_W-1:0] lpn_o  [N_ENT],
  output logic [1:0]       prot_o [N_ENT]
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic wr_here;
    assign wr_here = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[g]  <= 1'b0;
        lpn_o[g]  <= '0;
        prot_o[g] <= '0;
      end else if (wr_here) begin
        vld_o[g]  <= 1'b1;
        lpn_o[g]  <= wr_lpn_i;
        prot_o[g] <= wr_prot_i;
      end
    end
  end

  // R11
  prog_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_o[$past(wr_idx_i)] && (lpn_o[$past(wr_idx_i)] == $past(wr_lpn_i))
                && (prot_o[$past(wr_idx_i)] == $past(wr_prot_i)));
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int unsigned N_ENT = 128,
  parameter int unsigned IDX_W = 7,
  parameter int unsigned LPN_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i  [N_ENT],
  input  logic [LPN_W-1:0] lpn_i  [N_ENT],
  input  logic [LPN_W-1:0] req_lpn_i,
  input  logic [1:0]       psz_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [LPN_W-1:0] cmp_mask;
  logic [N_ENT-1:0] match_vec;

  // larger pages drop low page-number bits from the compare
  assign cmp_mask = ~((LPN_W'(1) << psz_i) - LPN_W'(1));

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match_vec[g] = vld_i[g] && (((lpn_i[g] ^ req_lpn_i) & cmp_mask) == '0);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  // R10
  lowest_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> match_vec[idx_o] && ((match_vec & ((N_ENT'(1) << idx_o) - N_ENT'(1))) == '0));
endmodule

// File: rtl/xlat_prot.sv
module xlat_prot
  import xlat_pkg::*;
(
  input  logic [1:0] prot_i,
  input  logic       wr_i,
  input  logic       priv_i,
  output logic       allow_o
);
  always_comb begin
    if (priv_i) allow_o = 1'b1;
    else begin
      unique case (prot_e'(prot_i))
        PROT_OPEN:   allow_o = 1'b1;
        PROT_RDONLY: allow_o = !wr_i;
        default:     allow_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/inv_page_xlat.sv
module inv_page_xlat #(
  parameter int unsigned N_PAGES    = 128,
  parameter int unsigned ADDR_W     = 25,
  parameter int unsigned BASE_SHIFT = 12,
  localparam int unsigned IDX_W     = $clog2(N_PAGES),
  localparam int unsigned LPN_W     = ADDR_W - BASE_SHIFT,
  localparam int unsigned MAX_SHIFT = BASE_SHIFT + 3,
  localparam int unsigned PA_W      = IDX_W + MAX_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              priv_i,
  input  logic [1:0]        psz_i,
  input  logic              prog_en_i,
  input  logic [IDX_W-1:0]  prog_idx_i,
  input  logic [LPN_W-1:0]  prog_lpn_i,
  input  logic [1:0]        prog_prot_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic              abort_o,
  output logic [PA_W-1:0]   paddr_o
);
  logic             tbl_vld  [N_PAGES];
  logic [LPN_W-1:0] tbl_lpn  [N_PAGES];
  logic [1:0]       tbl_prot [N_PAGES];

  logic             m_hit;
  logic [IDX_W-1:0] m_idx;
  logic             allow;
  logic [PA_W-1:0]  off_mask;
  logic [PA_W-1:0]  pa_d;

  xlat_entry_table #(.N_ENT(N_PAGES), .IDX_W(IDX_W), .LPN_W(LPN_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (prog_en_i),
    .wr_idx_i  (prog_idx_i),
    .wr_lpn_i  (prog_lpn_i),
    .wr_prot_i (prog_prot_i),
    .vld_o     (tbl_vld),
    .lpn_o     (tbl_lpn),
    .prot_o    (tbl_prot)
  );

  xlat_match #(.N_ENT(N_PAGES), .IDX_W(IDX_W), .LPN_W(LPN_W)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (tbl_vld),
    .lpn_i     (tbl_lpn),
    .req_lpn_i (addr_i[ADDR_W-1:BASE_SHIFT]),
    .psz_i     (psz_i),
    .hit_o     (m_hit),
    .idx_o     (m_idx)
  );

  xlat_prot u_prot (
    .prot_i  (tbl_prot[m_idx]),
    .wr_i    (wr_i),
    .priv_i  (priv_i),
    .allow_o (allow)
  );

  assign off_mask = (PA_W'(1) << (BASE_SHIFT + 32'(psz_i))) - PA_W'(1);
  assign pa_d     = (PA_W'(m_idx) << (BASE_SHIFT + 32'(psz_i)))
                  | (PA_W'(addr_i[MAX_SHIFT-1:0]) & off_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      abort_o     <= 1'b0;
      paddr_o     <= '0;
    end else begin
      rsp_valid_o <= req_i;
      hit_o       <= req_i && m_hit;
      abort_o     <= req_i && !(m_hit && allow);
      paddr_o     <= (req_i && m_hit && allow) ? pa_d : '0;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o && !hit_o && !abort_o);
  // R5
  miss_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !hit_o |-> abort_o && (paddr_o == '0));
  // R9
  sup_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && hit_o && $past(priv_i) |-> !abort_o);
endmodule

// File: tb/inv_page_xlat_bench.sv
module inv_page_xlat_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [24:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic        priv_i = 1'b0;
  logic [1:0]  psz_i = '0;
  logic        prog_en_i = 1'b0;
  logic [6:0]  prog_idx_i = '0;
  logic [12:0] prog_lpn_i = '0;
  logic [1:0]  prog_prot_i = '0;
  logic        rsp_valid_o, hit_o, abort_o;
  logic [21:0] paddr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  inv_page_xlat u_inv_page_xlat (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .wr_i(wr_i),
    .priv_i(priv_i), .psz_i(psz_i), .prog_en_i(prog_en_i), .prog_idx_i(prog_idx_i),
    .prog_lpn_i(prog_lpn_i), .prog_prot_i(prog_prot_i), .rsp_valid_o(rsp_valid_o),
    .hit_o(hit_o), .abort_o(abort_o), .paddr_o(paddr_o)
  );

  always #2 clk_i = ~clk_i;

  function automatic logic [21:0] pa_of(input int idx, input logic [24:0] a, input int sz);
    logic [21:0] m;
    m = (22'd1 << (12 + sz)) - 22'd1;
    return (22'(idx) << (12 + sz)) | (22'(a) & m);
  endfunction

  function automatic logic [24:0] la(input logic [12:0] lpn, input logic [11:0] off);
    return {lpn, off};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string what, input string got, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %s expected %s", what, got, exp);
    end
  endtask

  // driver: present one request for one cycle, queue its expected result
  task automatic access(input logic [24:0] a, input bit wr, input bit sup, input int sz,
                        input bit e_hit, input bit e_abort, input logic [21:0] e_pa,
                        input string tag);
    addr_i = a; wr_i = wr; priv_i = sup; psz_i = 2'(sz); req_i = 1'b1;
    exp_q.push_back({e_hit, e_abort, e_pa});
    tag_q.push_back(tag);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic prog(input int idx, input logic [12:0] lpn, input int prot);
    prog_en_i = 1'b1; prog_idx_i = 7'(idx); prog_lpn_i = lpn; prog_prot_i = 2'(prot);
    @(negedge clk_i);
    prog_en_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", "rsp_valid=1", "no response");
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({hit_o, abort_o, paddr_o} == e, t,
              $sformatf("hit=%0b abort=%0b pa=%06h", hit_o, abort_o, paddr_o),
              $sformatf("hit=%0b abort=%0b pa=%06h", e[23], e[22], e[21:0]));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check({rsp_valid_o, hit_o, abort_o, paddr_o} == '0, "R1 reset outputs",
          $sformatf("%b %b %b %h", rsp_valid_o, hit_o, abort_o, paddr_o), "0 0 0 0");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({rsp_valid_o, hit_o, abort_o} == '0, "R2 idle outputs",
          $sformatf("%b %b %b", rsp_valid_o, hit_o, abort_o), "0 0 0");
    // R1 all slots invalid, page 0 too
    access(la(13'h0000, 12'h010), 1'b0, 1'b1, 0, 1'b0, 1'b1, 22'h0, "R1 invalid slot page0");
    access(la(13'h0123, 12'h010), 1'b0, 1'b0, 0, 1'b0, 1'b1, 22'h0, "R1 invalid slot");

    prog(5,  13'h0123, 0);
    prog(9,  13'h0200, 1);
    prog(10, 13'h0300, 2);
    prog(11, 13'h0400, 3);
    prog(20, 13'h0500, 0);
    prog(3,  13'h0500, 0);

    // R3 R6 basic translation
    access(la(13'h0123, 12'hABC), 1'b0, 1'b0, 0, 1'b1, 1'b0, pa_of(5, la(13'h0123, 12'hABC), 0), "R3 R6 user read 4K");
    access(la(13'h0123, 12'h001), 1'b1, 1'b0, 0, 1'b1, 1'b0, pa_of(5, la(13'h0123, 12'h001), 0), "R6 user write lvl0");
    // R5 miss
    access(la(13'h0124, 12'h000), 1'b0, 1'b0, 0, 1'b0, 1'b1, 22'h0, "R5 miss");
    // R7
    access(la(13'h0200, 12'h345), 1'b0, 1'b0, 0, 1'b1, 1'b0, pa_of(9, la(13'h0200, 12'h345), 0), "R7 user read lvl1");
    access(la(13'h0200, 12'h345), 1'b1, 1'b0, 0, 1'b1, 1'b1, 22'h0, "R7 user write lvl1");
    // R8
    access(la(13'h0300, 12'h777), 1'b0, 1'b0, 0, 1'b1, 1'b1, 22'h0, "R8 user read lvl2");
    access(la(13'h0400, 12'h777), 1'b1, 1'b0, 0, 1'b1, 1'b1, 22'h0, "R8 user write lvl3");
    access(la(13'h0400, 12'h777), 1'b0, 1'b0, 0, 1'b1, 1'b1, 22'h0, "R8 user read lvl3");
    // R9
    access(la(13'h0400, 12'h777), 1'b1, 1'b1, 0, 1'b1, 1'b0, pa_of(11, la(13'h0400, 12'h777), 0), "R9 sup write lvl3");
    access(la(13'h0200, 12'h002), 1'b1, 1'b1, 0, 1'b1, 1'b0, pa_of(9, la(13'h0200, 12'h002), 0), "R9 sup write lvl1");
    // R10
    access(la(13'h0500, 12'h0F0), 1'b0, 1'b0, 0, 1'b1, 1'b0, pa_of(3, la(13'h0500, 12'h0F0), 0), "R10 lowest slot");
    // R4 page sizes
    access(la(13'h0122, 12'h456), 1'b0, 1'b0, 1, 1'b1, 1'b0, pa_of(5, la(13'h0122, 12'h456), 1), "R4 8K");
    access(la(13'h0121, 12'hFFF), 1'b0, 1'b0, 2, 1'b1, 1'b0, pa_of(5, la(13'h0121, 12'hFFF), 2), "R4 16K");
    access(la(13'h0127, 12'h000), 1'b0, 1'b0, 2, 1'b0, 1'b1, 22'h0, "R4 16K miss");
    access(la(13'h0120, 12'hFFF), 1'b1, 1'b0, 3, 1'b1, 1'b0, pa_of(5, la(13'h0120, 12'hFFF), 3), "R4 32K");
    access(la(13'h0201, 12'h0AA), 1'b1, 1'b0, 1, 1'b1, 1'b1, 22'h0, "R4 R7 8K write lvl1");

    // R11 same-cycle write is not seen, next cycle is
    prog_en_i = 1'b1; prog_idx_i = 7'd30; prog_lpn_i = 13'h0800; prog_prot_i = 2'd0;
    access(la(13'h0800, 12'h123), 1'b0, 1'b0, 0, 1'b0, 1'b1, 22'h0, "R11 same cycle old view");
    prog_en_i = 1'b0;
    access(la(13'h0800, 12'h123), 1'b0, 1'b0, 0, 1'b1, 1'b0, pa_of(30, la(13'h0800, 12'h123), 0), "R11 next cycle new view");

    // R12 reprogram slot 5
    prog(5, 13'h0700, 0);
    access(la(13'h0123, 12'h000), 1'b0, 1'b0, 0, 1'b0, 1'b1, 22'h0, "R12 old mapping gone");
    access(la(13'h0700, 12'h00C), 1'b0, 1'b0, 0, 1'b1, 1'b0, pa_of(5, la(13'h0700, 12'h00C), 0), "R12 new mapping");

    repeat (3) @(negedge clk_i);
    // R2 no pending responses left
    check(exp_q.size() == 0, "R2 all responses returned",
          $sformatf("%0d pending", exp_q.size()), "0 pending");
    finish_run();
  end
endmodule